// File: doc/BRIEF.md
# Three-Wire Serial Command Receiver

This block is the device-side front end of a small serial memory that sits on a three-wire select/clock/data bus. The bus master raises chip select, may clock any number of zeros, and then sends a one as the start marker. A two-bit opcode follows, then an address field, then a data word for commands that write. The block collects these bits on rising edges of the serial clock and decodes the command. It then presents the command kind, address and data to the memory core as parallel fields, together with a valid level. For reads, it shifts the word that the core returns out on the data-out pin.

Chip select low is an asynchronous reset for all of the receiver's state, so every instruction starts from a clean idle. Once a command has used its fixed number of bits, the block ignores the clock and data pins until select drops again. While the block waits for a start bit with select high, the data-out pin can report the ready or busy state of the programming engine. A width input picks 16-bit words with a 6-bit address or 8-bit words with a 7-bit address.

Top module: `mwrx_top`

## Requirements
- R1: While `csel` is low, `doutEn` and `cmdValid` are low and all receiver state is cleared, whatever `sclk` and `din` do.
- R2: With `csel` high, each rising `sclk` edge that samples `din` = 0 before a start bit leaves the receiver idle with no command. The first rising edge that samples `din` = 1 is the start bit.
- R3: The two bits after the start bit form the opcode, first bit in the high position. The opcode and `cmdKind` codes are: 10 gives read (0), 01 gives write (1), 11 gives erase (2). Opcode 00 is extended, and the top two address bits then pick the command: 11 gives write-enable (3), 00 gives write-disable (4), 10 gives erase-all (5), 01 gives write-all (6).
- R4: The address field follows the opcode, MSB first. It is 6 bits when `wideMode` = 1 and 7 bits when `wideMode` = 0, and it appears zero-extended on `cmdAddr`.
- R5: Write (opcode 01) and write-all take a data word after the address, MSB first. The word is 16 bits in wide mode and 8 bits in narrow mode, and it appears zero-extended on `cmdData`.
- R6: `cmdValid` stays low until the rising edge that samples the last bit the command needs. It goes high on that edge and stays high until `csel` falls.
- R7: After a command is complete, further clock edges with any `din` pattern change neither `cmdValid`, `cmdKind`, `cmdAddr` nor `cmdData`, and they start no new command.
- R8: For a read, the edge of the last address bit enables `dout` and drives it to 0. On each of the following edges, `dout` carries the next bit of the word from `rdData`, starting with the MSB. The edge after the last data bit releases `doutEn`.
- R9: In narrow mode, a read shifts out `rdData[7:0]` only.
- R10: While `csel` is high and no start bit has been seen, `pendStatus` = 1 enables `dout`, which then shows `~busyIn` (1 = ready). The start bit ends this status output.
- R11: Holding `sclk` high or low for any time between edges does not change the bits that are received or sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; bits are sampled and driven on its rising edge |
| csel | input | 1 | Chip select, active high; low resets the receiver |
| din | input | 1 | Serial data in |
| wideMode | input | 1 | 1 = 16-bit words and 6-bit address, 0 = 8-bit words and 7-bit address |
| busyIn | input | 1 | Programming engine busy |
| pendStatus | input | 1 | Engine asks for its ready/busy state to be shown on `dout` |
| rdData | input | 16 | Word read from the array at `cmdAddr` |
| dout | output | 1 | Serial data out value |
| doutEn | output | 1 | Output enable for `dout`; when low the pin floats |
| cmdValid | output | 1 | Decoded command fields are valid |
| cmdKind | output | 3 | Decoded command code |
| cmdAddr | output | 7 | Received address, zero-extended |
| cmdData | output | 16 | Received data word, zero-extended |

## Verification
The hardest case to reach from the ports is the read hand-off. On a single edge the receiver must report the address, drive the dummy zero, and capture the core's word one edge later, all while the clock may pause at either level. The bench models the array as a function of `cmdAddr` and runs reads in both widths at the extreme addresses and at random addresses. It stretches random clock phases and follows every command with random trailing clocks that contain start-like ones, to show that they are ignored.

// File: rtl/mwrx_pkg.sv
package mwrx_pkg;

  typedef enum logic [2:0] {
    CMD_READ     = 3'd0,
    CMD_WRITE    = 3'd1,
    CMD_ERASE    = 3'd2,
    CMD_WREN     = 3'd3,
    CMD_WRDIS    = 3'd4,
    CMD_ERASEALL = 3'd5,
    CMD_WRITEALL = 3'd6
  } cmdKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_RDOUT,
    ST_DONE
  } rxState_e;

  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic latchData;
    logic loadOut;
    logic shiftOut;
  } dpStrobe_t;

endpackage

// File: rtl/mwrx_ctrl.sv
module mwrx_ctrl
  import mwrx_pkg::*;
#(
  parameter int AW_WIDE   = 6,
  parameter int AW_NARROW = 7,
  parameter int DW_WIDE   = 16,
  parameter int DW_NARROW = 8,
  parameter int CW        = 5
) (
  input  logic          sclk,
  input  logic          csel,
  input  logic          din,
  input  logic          wideMode,
  input  logic          pendStatus,
  input  logic [1:0]    lowBits,
  output dpStrobe_t     strobe,
  output logic [CW-1:0] addrLen,
  output logic [CW-1:0] dataLen,
  output logic          cmdValid,
  output logic [2:0]    cmdKind,
  output logic          rdActive,
  output logic          rdDummy,
  output logic          doutEn
);

  rxState_e      state, stateNext;
  logic [CW-1:0] bitCnt, cntNext, newCnt;
  logic [1:0]    opReg, subReg;
  cmdKind_e      kindReg;
  logic          needData;

  function automatic cmdKind_e decodeKind(input logic [1:0] op, input logic [1:0] sub);
    case (op)
      2'b10:   decodeKind = CMD_READ;
      2'b01:   decodeKind = CMD_WRITE;
      2'b11:   decodeKind = CMD_ERASE;
      default: begin
        case (sub)
          2'b11:   decodeKind = CMD_WREN;
          2'b00:   decodeKind = CMD_WRDIS;
          2'b10:   decodeKind = CMD_ERASEALL;
          default: decodeKind = CMD_WRITEALL;
        endcase
      end
    endcase
  endfunction

  assign addrLen  = wideMode ? CW'(AW_WIDE) : CW'(AW_NARROW);
  assign dataLen  = wideMode ? CW'(DW_WIDE) : CW'(DW_NARROW);
  assign newCnt   = bitCnt + CW'(1);
  assign needData = (opReg == 2'b01) || (opReg == 2'b00 && subReg == 2'b01);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    cntNext   = bitCnt;
    case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (din) stateNext = ST_SHIFT;
      end
      ST_SHIFT: begin
        strobe.shiftIn = 1'b1;
        cntNext        = newCnt;
        if (newCnt == CW'(2) + addrLen) begin
          strobe.latchAddr = 1'b1;
          if (!needData) begin
            stateNext = (opReg == 2'b10) ? ST_RDOUT : ST_DONE;
            cntNext   = '0;
          end
        end else if (needData && newCnt == CW'(2) + addrLen + dataLen) begin
          strobe.latchData = 1'b1;
          stateNext        = ST_DONE;
        end
      end
      ST_RDOUT: begin
        cntNext = newCnt;
        if (bitCnt == '0)            strobe.loadOut  = 1'b1;
        else if (bitCnt == dataLen)  stateNext       = ST_DONE;
        else                         strobe.shiftOut = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge sclk or negedge csel) begin
    if (!csel) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      opReg   <= '0;
      subReg  <= '0;
      kindReg <= CMD_READ;
    end else begin
      state  <= stateNext;
      bitCnt <= cntNext;
      if (state == ST_SHIFT && newCnt == CW'(2)) opReg  <= lowBits;
      if (state == ST_SHIFT && newCnt == CW'(4)) subReg <= lowBits;
      if (state == ST_SHIFT && (stateNext == ST_RDOUT || stateNext == ST_DONE))
        kindReg <= decodeKind(opReg, subReg);
    end
  end

  assign cmdValid = (state == ST_RDOUT) || (state == ST_DONE);
  assign cmdKind  = kindReg;
  assign rdActive = (state == ST_RDOUT);
  assign rdDummy  = (bitCnt == '0);
  assign doutEn   = csel && (rdActive || (state == ST_IDLE && pendStatus));

endmodule

// File: rtl/mwrx_dpath.sv
module mwrx_dpath
  import mwrx_pkg::*;
#(
  parameter int AMAX = 7,
  parameter int DMAX = 16,
  parameter int CW   = 5
) (
  input  logic            sclk,
  input  logic            csel,
  input  logic            din,
  input  dpStrobe_t       strobe,
  input  logic [CW-1:0]   addrLen,
  input  logic [CW-1:0]   dataLen,
  input  logic [DMAX-1:0] rdData,
  input  logic            rdActive,
  input  logic            rdDummy,
  input  logic            busyIn,
  output logic [1:0]      lowBits,
  output logic [AMAX-1:0] cmdAddr,
  output logic [DMAX-1:0] cmdData,
  output logic            dout
);

  logic [DMAX-2:0] frame;
  logic [DMAX-1:0] frameNext;
  logic [AMAX-1:0] addrCap;
  logic [DMAX-1:0] dataCap;
  logic [DMAX-1:0] outReg, outLoad;
  logic [CW-1:0]   alignShift;

  assign frameNext  = {frame, din};
  assign lowBits    = frameNext[1:0];
  assign alignShift = CW'(DMAX) - dataLen;
  assign outLoad    = rdData << alignShift;

  always_comb begin
    for (int i = 0; i < AMAX; i++) addrCap[i] = frameNext[i] && (i < int'(addrLen));
    for (int i = 0; i < DMAX; i++) dataCap[i] = frameNext[i] && (i < int'(dataLen));
  end

  always_ff @(posedge sclk or negedge csel) begin
    if (!csel) begin
      frame   <= '0;
      cmdAddr <= '0;
      cmdData <= '0;
      outReg  <= '0;
    end else begin
      if (strobe.shiftIn)   frame   <= frameNext[DMAX-2:0];
      if (strobe.latchAddr) cmdAddr <= addrCap;
      if (strobe.latchData) cmdData <= dataCap;
      if (strobe.loadOut)        outReg <= outLoad;
      else if (strobe.shiftOut)  outReg <= outReg << 1;
    end
  end

  assign dout = rdActive ? (!rdDummy && outReg[DMAX-1]) : !busyIn;

endmodule

// File: rtl/mwrx_top.sv
module mwrx_top
  import mwrx_pkg::*;
#(
  parameter int AW_WIDE   = 6,
  parameter int AW_NARROW = 7,
  parameter int DW_WIDE   = 16,
  parameter int DW_NARROW = 8,
  localparam int AMAX = (AW_WIDE > AW_NARROW) ? AW_WIDE : AW_NARROW,
  localparam int DMAX = (DW_WIDE > DW_NARROW) ? DW_WIDE : DW_NARROW,
  localparam int CW   = $clog2(2 + AMAX + DMAX + 1)
) (
  input  logic            sclk,
  input  logic            csel,
  input  logic            din,
  input  logic            wideMode,
  input  logic            busyIn,
  input  logic            pendStatus,
  input  logic [DMAX-1:0] rdData,
  output logic            dout,
  output logic            doutEn,
  output logic            cmdValid,
  output logic [2:0]      cmdKind,
  output logic [AMAX-1:0] cmdAddr,
  output logic [DMAX-1:0] cmdData
);

  dpStrobe_t     strobe;
  logic [CW-1:0] addrLen, dataLen;
  logic [1:0]    lowBits;
  logic          rdActive, rdDummy;

  mwrx_ctrl #(
    .AW_WIDE(AW_WIDE), .AW_NARROW(AW_NARROW),
    .DW_WIDE(DW_WIDE), .DW_NARROW(DW_NARROW), .CW(CW)
  ) u_ctrl (
    .sclk(sclk), .csel(csel), .din(din), .wideMode(wideMode),
    .pendStatus(pendStatus), .lowBits(lowBits), .strobe(strobe),
    .addrLen(addrLen), .dataLen(dataLen), .cmdValid(cmdValid),
    .cmdKind(cmdKind), .rdActive(rdActive), .rdDummy(rdDummy),
    .doutEn(doutEn)
  );

  mwrx_dpath #(.AMAX(AMAX), .DMAX(DMAX), .CW(CW)) u_dpath (
    .sclk(sclk), .csel(csel), .din(din), .strobe(strobe),
    .addrLen(addrLen), .dataLen(dataLen), .rdData(rdData),
    .rdActive(rdActive), .rdDummy(rdDummy), .busyIn(busyIn),
    .lowBits(lowBits), .cmdAddr(cmdAddr), .cmdData(cmdData), .dout(dout)
  );

endmodule

// File: rtl/mwrx_check.sv
module mwrx_check #(
  parameter int AMAX = 7,
  parameter int DMAX = 16
) (
  input logic            sclk,
  input logic            csel,
  input logic            dout,
  input logic            doutEn,
  input logic            cmdValid,
  input logic [2:0]      cmdKind,
  input logic [AMAX-1:0] cmdAddr,
  input logic [DMAX-1:0] cmdData
);

  AST_DESELECT_QUIET: assert property (@(negedge sclk) !csel |-> (!doutEn && !cmdValid)); // R1

  AST_VALID_STICKY: assert property (@(posedge sclk) disable iff (!csel)
    cmdValid |=> cmdValid); // R6

  AST_FIELDS_FROZEN: assert property (@(posedge sclk) disable iff (!csel)
    cmdValid |=> ($stable(cmdKind) && $stable(cmdAddr) && $stable(cmdData))); // R7

  AST_READ_DUMMY: assert property (@(posedge sclk) disable iff (!csel)
    ($rose(cmdValid) && cmdKind == 3'd0) |-> (doutEn && !dout)); // R8

endmodule

bind mwrx_top mwrx_check #(.AMAX(AMAX), .DMAX(DMAX)) u_check (
  .sclk(sclk), .csel(csel), .dout(dout), .doutEn(doutEn),
  .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdData(cmdData)
);

// File: tb/mwrx_top_test.sv
module mwrx_top_test;
  localparam int CLK_PERIOD = 20;
  localparam int HALF = CLK_PERIOD / 2;

  logic        sclk = 0, csel = 0, din = 0, wideMode = 1, busyIn = 0, pendStatus = 0;
  logic [15:0] rdData;
  logic        dout, doutEn, cmdValid;
  logic [2:0]  cmdKind;
  logic [6:0]  cmdAddr;
  logic [15:0] cmdData;

  int  total = 0, bad = 0;
  bit  stallOn = 0;
  bit  finished = 0;

  mwrx_top uut (
    .sclk(sclk), .csel(csel), .din(din), .wideMode(wideMode), .busyIn(busyIn),
    .pendStatus(pendStatus), .rdData(rdData), .dout(dout), .doutEn(doutEn),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdAddr(cmdAddr), .cmdData(cmdData)
  );

  function automatic logic [15:0] memWord(input int a);
    memWord = 16'(a * 40503) ^ 16'h5A3C;
  endfunction

  assign rdData = memWord(int'(cmdAddr));

  function automatic int expKind(input logic [1:0] op, input logic [1:0] sub);
    case (op)
      2'b10: expKind = 0;
      2'b01: expKind = 1;
      2'b11: expKind = 2;
      default: case (sub)
        2'b11: expKind = 3;
        2'b00: expKind = 4;
        2'b10: expKind = 5;
        default: expKind = 6;
      endcase
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    din = b;
    #HALF;
    if (stallOn) #(HALF * $urandom_range(0, 3));
    sclk = 1;
    #HALF;
    if (stallOn) #(HALF * $urandom_range(0, 3));
    sclk = 0;
  endtask

  task automatic runCmd(input bit wide, input logic [1:0] op, input int addr, input int data,
                        input int idleZeros, input int tail, input bit pend, input bit busy);
    int aw, dw, sub, expData, expWord;
    bit nd, isRead;
    aw = wide ? 6 : 7;
    dw = wide ? 16 : 8;
    sub = (addr >> (aw - 2)) & 3;
    nd = (op == 2'b01) || (op == 2'b00 && sub == 1);
    isRead = (op == 2'b10);
    expData = data & ((1 << dw) - 1);

    csel = 0; wideMode = wide; pendStatus = pend; busyIn = busy; din = 0;
    #CLK_PERIOD;
    pulse(1); pulse(1);
    check(!doutEn && !cmdValid, "R1", "quiet while deselected", {doutEn, cmdValid}, 0);
    csel = 1;
    #1;
    if (pend) check(doutEn && dout == !busy, "R10", "status shown", {doutEn, dout}, {1'b1, !busy});
    else      check(!doutEn, "R10", "no status", doutEn, 0);
    for (int i = 0; i < idleZeros; i++) pulse(0);
    check(!cmdValid, "R2", "idle clocks give no command", cmdValid, 0);
    pulse(1);
    check(!doutEn, "R10", "start bit ends status", doutEn, 0);
    pulse(op[1]); pulse(op[0]);
    for (int i = aw - 1; i >= 0; i--) begin
      if (i == 0) check(!cmdValid, "R6", "not valid before last address bit", cmdValid, 0);
      pulse(logic'((addr >> i) & 1));
    end
    if (nd) begin
      for (int i = dw - 1; i >= 0; i--) begin
        if (i == 0) check(!cmdValid, "R6", "not valid before last data bit", cmdValid, 0);
        pulse(logic'((data >> i) & 1));
      end
    end
    check(cmdValid, "R6", "valid after last bit", cmdValid, 1);
    check(int'(cmdKind) == expKind(op, 2'(sub)), "R3", "kind", cmdKind, expKind(op, 2'(sub)));
    check(int'(cmdAddr) == addr, "R4", "address", cmdAddr, addr);
    if (nd) check(int'(cmdData) == expData, "R5", "data word", cmdData, expData);
    if (isRead) begin
      check(doutEn && !dout, "R8", "dummy zero", {doutEn, dout}, 2);
      expWord = wide ? int'(memWord(addr)) : int'(memWord(addr)) & 255;
      for (int i = dw - 1; i >= 0; i--) begin
        pulse(logic'($urandom_range(0, 1)));
        if (wide) check(doutEn && dout == ((expWord >> i) & 1), "R8", "read bit", dout, (expWord >> i) & 1);
        else      check(doutEn && dout == ((expWord >> i) & 1), "R9", "narrow read bit", dout, (expWord >> i) & 1);
      end
      pulse(0);
      check(!doutEn, "R8", "released after word", doutEn, 0);
    end
    for (int i = 0; i < tail; i++) pulse(logic'(i < 2 ? 1 : $urandom_range(0, 1)));
    check(cmdValid && int'(cmdKind) == expKind(op, 2'(sub)) && int'(cmdAddr) == addr
          && (!nd || int'(cmdData) == expData) && !doutEn,
          "R7", "trailing clocks ignored", {cmdValid, cmdKind}, {1'b1, 3'(expKind(op, 2'(sub)))});
    csel = 0;
    #1;
    check(!cmdValid && !doutEn, "R1", "cleared on deselect", {doutEn, cmdValid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    #(CLK_PERIOD);
    check(!doutEn && !cmdValid && cmdAddr == 0, "R1", "reset state", {doutEn, cmdValid}, 0);
    runCmd(1, 2'b10, 0, 0, 0, 3, 0, 0);
    runCmd(1, 2'b10, 63, 0, 20, 4, 1, 1);
    runCmd(0, 2'b10, 127, 0, 5, 2, 1, 0);
    runCmd(1, 2'b01, 21, 16'hFFFF, 1, 5, 0, 0);
    runCmd(0, 2'b01, 99, 16'h00A5, 0, 5, 0, 0);
    runCmd(1, 2'b11, 7, 0, 2, 3, 0, 0);
    runCmd(1, 2'b00, 6'b110101, 0, 0, 3, 0, 0);
    runCmd(1, 2'b00, 6'b000011, 0, 0, 3, 0, 0);
    runCmd(0, 2'b00, 7'b1000001, 0, 0, 3, 0, 0);
    runCmd(0, 2'b00, 7'b0110000, 16'h003C, 0, 3, 0, 0);
    stallOn = 1;  // R11: stretched clock phases
    runCmd(1, 2'b10, 42, 0, 3, 3, 0, 0);
    runCmd(0, 2'b00, 7'b0100110, 16'h00C3, 1, 3, 0, 0);
    for (int n = 0; n < 60; n++) begin
      stallOn = ($urandom_range(0, 2) == 0);
      runCmd(bit'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             int'($urandom_range(0, 63)), int'($urandom_range(0, 65535)),
             int'($urandom_range(0, 6)), int'($urandom_range(0, 6)),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule